// File: doc/BRIEF.md
# Complex / Dual-Real Multiply-Accumulate Unit

This block multiply-accumulates pairs of packed operand words. Each operand word holds two signed fixed-point halves of `DW` bits. A per-operation mode bit sets how the halves are read. In complex mode the low half is the real part and the high half is the imaginary part, and one complex product is folded into a complex accumulator. In dual-real mode the two halves are separate samples of two independent channels, and each channel keeps its own running sum.

A shared array of four signed multipliers feeds two accumulator lanes. Each lane is `2*DW + GUARD` bits wide. A lane either clamps at its rails when saturation is enabled or wraps in two's complement when it is not. In both cases the lane records a sticky overflow flag. Alongside the raw accumulators, the block presents a scaled-down result per lane, shifted right by `DW-1` bits. This result is truncated toward minus infinity, or rounded half-up when rounding is enabled. Rounding acts only on the output and never alters the stored sums.

Top module: `cmac_dual`

## Requirements
- R1: Packing: operand half 0 is bits [DW-1:0] and half 1 is bits [2*DW-1:DW]. Lane 0 occupies the low AW bits of `acc_out` and the low OW bits of `res_out`. Lane 1 occupies the high AW and OW bits. Here AW = 2*DW+GUARD and OW = AW-DW+1.
- R2: With `cplx_mode`=1, lane 0 adds a0*b0 - a1*b1 and lane 1 adds a0*b1 + a1*b0.
- R3: With `cplx_mode`=0, lane 0 adds a0*b0 and lane 1 adds a1*b1. The two cross multipliers are forced to zero.
- R4: A new operation is accepted on every clock with `in_valid`=1, and the mode may change from one operation to the next. An operation sampled at clock edge N appears on `acc_out` after edge N+1.
- R5: `acc_clr`=1 together with `in_valid`=1 loads the new lane terms in place of the old sums and clears both overflow flags.
- R6: While `in_valid`=0, `op_a`, `op_b`, `acc_clr`, `cplx_mode` and `sat_en` have no effect on the accumulators or the flags.
- R7: With `sat_en`=1, a sum beyond the AW-bit signed range is replaced by 2^(AW-1)-1 or -2^(AW-1), and the lane's `ovf` bit is set.
- R8: With `sat_en`=0, an out-of-range sum wraps modulo 2^AW, and the lane's `ovf` bit is still set.
- R9: A set `ovf` bit stays set through later accumulations, including ones that do not overflow, until a clear-load or reset.
- R10: `res_out` per lane equals floor(acc / 2^(DW-1)) when `rnd_en`=0, and floor((acc + 2^(DW-2)) / 2^(DW-1)) when `rnd_en`=1. A value above the OW-bit positive limit becomes 2^(OW-1)-1. `rnd_en` acts combinationally and never changes `acc_out`.
- R11: Synchronous active-high `rst` zeroes both accumulators and both overflow flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| acc_clr | input | 1 | Load instead of add (with in_valid) |
| cplx_mode | input | 1 | 1 = complex, 0 = dual real |
| sat_en | input | 1 | Clamp on accumulator overflow |
| rnd_en | input | 1 | Round half-up on the scaled output |
| op_a | input | 2*DW | Packed operand A {a1, a0} |
| op_b | input | 2*DW | Packed operand B {b1, b0} |
| acc_out | output | 2*AW | Packed raw accumulators {lane1, lane0} |
| res_out | output | 2*OW | Packed scaled results {lane1, lane0} |
| ovf | output | 2 | Sticky overflow flag per lane |

## Verification
Two functions can meet in the same cycle: an accumulation that overflows and sets a lane's flag, and a clear-load that must drop that flag. The bench drives a long burst of near-full-scale complex products with saturation enabled and issues a clear-load on the very next clock, with no idle gap. The result passes only if the flag reads zero, the lane holds exactly the new terms, and no stale rail value survives. A second overlap is rounding applied to a value pinned at the positive rail. This is judged by expecting the clamped output limit rather than a wrapped negative number.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

    typedef enum logic {
        MODE_DUAL = 1'b0,
        MODE_CPLX = 1'b1
    } mac_mode_e;

    typedef struct packed {
        logic vld;
        logic clr;
        logic sat;
    } mac_ctl_t;

    localparam int N_LANES = 2;
    localparam int N_MULTS = 4;

endpackage

// File: rtl/cmac_mult_array.sv
module cmac_mult_array
    import cmac_pkg::*;
#(
    parameter int DW = 16
) (
    input  mac_mode_e                 mode,
    input  logic [2*DW-1:0]           op_a,
    input  logic [2*DW-1:0]           op_b,
    output logic signed [2*DW:0]      term0,
    output logic signed [2*DW:0]      term1,
    output logic [4*DW-1:0]           cross_prods
);
    localparam int PW = 2 * DW;
    localparam int TW = PW + 1;

    logic signed [DW-1:0] ma [N_MULTS];
    logic signed [DW-1:0] mb [N_MULTS];
    logic signed [PW-1:0] pr [N_MULTS];

    always_comb begin
        ma[0] = op_a[DW-1:0];
        mb[0] = op_b[DW-1:0];
        ma[1] = op_a[2*DW-1:DW];
        mb[1] = op_b[2*DW-1:DW];
        // cross multipliers only see data in complex mode
        if (mode == MODE_CPLX) begin
            ma[2] = op_a[DW-1:0];
            mb[2] = op_b[2*DW-1:DW];
            ma[3] = op_a[2*DW-1:DW];
            mb[3] = op_b[DW-1:0];
        end else begin
            ma[2] = '0;
            mb[2] = '0;
            ma[3] = '0;
            mb[3] = '0;
        end
    end

    for (genvar k = 0; k < N_MULTS; k++) begin : g_mul
        assign pr[k] = ma[k] * mb[k];
    end

    always_comb begin
        if (mode == MODE_CPLX) begin
            term0 = TW'(pr[0]) - TW'(pr[1]);
            term1 = TW'(pr[2]) + TW'(pr[3]);
        end else begin
            term0 = TW'(pr[0]);
            term1 = TW'(pr[1]);
        end
    end

    assign cross_prods = {pr[3], pr[2]};

endmodule

// File: rtl/cmac_lane_acc.sv
module cmac_lane_acc #(
    parameter int TW = 33,
    parameter int AW = 40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 clr,
    input  logic                 sat,
    input  logic signed [TW-1:0] term,
    output logic signed [AW-1:0] acc,
    output logic                 ovf
);
    localparam logic signed [AW+1:0] HI_LIM = {3'b000, {(AW-1){1'b1}}};
    localparam logic signed [AW+1:0] LO_LIM = {3'b111, {(AW-1){1'b0}}};
    localparam logic signed [AW-1:0] RAIL_P = {1'b0, {(AW-1){1'b1}}};
    localparam logic signed [AW-1:0] RAIL_N = {1'b1, {(AW-1){1'b0}}};

    logic signed [AW+1:0] sum;
    logic                 out_of_range;

    assign sum          = (AW+2)'(acc) + (AW+2)'(term);
    assign out_of_range = (sum > HI_LIM) || (sum < LO_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (en) begin
            if (clr) begin
                acc <= AW'(term);
                ovf <= 1'b0;
            end else begin
                if (out_of_range) begin
                    ovf <= 1'b1;
                end
                if (out_of_range && sat) begin
                    acc <= sum[AW+1] ? RAIL_N : RAIL_P;
                end else begin
                    acc <= sum[AW-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/cmac_round.sv
module cmac_round #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic signed [AW-1:0]      acc,
    input  logic                      rnd,
    output logic signed [AW-DW:0]     res
);
    localparam int OW = AW - DW + 1;
    localparam logic signed [AW:0] HALF = (AW+1)'(1) <<< (DW - 2);

    logic signed [AW:0] biased;
    logic signed [OW:0] scaled;

    assign biased = (AW+1)'(acc) + (rnd ? HALF : '0);
    assign scaled = (OW+1)'(biased >>> (DW - 1));

    always_comb begin
        if (scaled[OW] != scaled[OW-1]) begin
            res = {1'b0, {(OW-1){1'b1}}};
        end else begin
            res = scaled[OW-1:0];
        end
    end

endmodule

// File: rtl/cmac_dual.sv
module cmac_dual
    import cmac_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GUARD = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic                          acc_clr,
    input  logic                          cplx_mode,
    input  logic                          sat_en,
    input  logic                          rnd_en,
    input  logic [2*DW-1:0]               op_a,
    input  logic [2*DW-1:0]               op_b,
    output logic [2*(2*DW+GUARD)-1:0]     acc_out,
    output logic [2*(DW+GUARD+1)-1:0]     res_out,
    output logic [1:0]                    ovf
);
    localparam int PW = 2 * DW;
    localparam int TW = PW + 1;
    localparam int AW = PW + GUARD;
    localparam int OW = AW - DW + 1;

    logic signed [TW-1:0] new_term [N_LANES];
    logic signed [TW-1:0] s1_term  [N_LANES];
    logic [2*PW-1:0]      idle_prods;
    mac_ctl_t             s1_ctl;
    logic                 s1_vld, s1_clr, s1_sat;

    cmac_mult_array #(.DW(DW)) u_mults (
        .mode        (mac_mode_e'(cplx_mode)),
        .op_a        (op_a),
        .op_b        (op_b),
        .term0       (new_term[0]),
        .term1       (new_term[1]),
        .cross_prods (idle_prods)
    );

    // operand stage: control always, terms only when an op arrives
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_ctl <= '0;
        end else begin
            s1_ctl.vld <= in_valid;
            s1_ctl.clr <= acc_clr;
            s1_ctl.sat <= sat_en;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            s1_term[0] <= new_term[0];
            s1_term[1] <= new_term[1];
        end
    end

    assign s1_vld = s1_ctl.vld;
    assign s1_clr = s1_ctl.clr;
    assign s1_sat = s1_ctl.sat;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic signed [AW-1:0] lane_acc;
        logic signed [OW-1:0] lane_res;

        cmac_lane_acc #(.TW(TW), .AW(AW)) u_acc (
            .clk  (clk),
            .rst  (rst),
            .en   (s1_vld),
            .clr  (s1_clr),
            .sat  (s1_sat),
            .term (s1_term[i]),
            .acc  (lane_acc),
            .ovf  (ovf[i])
        );

        cmac_round #(.DW(DW), .AW(AW)) u_rnd (
            .acc (lane_acc),
            .rnd (rnd_en),
            .res (lane_res)
        );

        assign acc_out[i*AW +: AW] = lane_acc;
        assign res_out[i*OW +: OW] = lane_res;
    end

endmodule

// File: rtl/cmac_dual_chk.sv
module cmac_dual_chk #(
    parameter int AW = 40,
    parameter int PW = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            s1_vld,
    input logic            s1_clr,
    input logic            s1_sat,
    input logic            cplx_mode,
    input logic [2*PW-1:0] idle_prods,
    input logic [2*AW-1:0] acc_out,
    input logic [1:0]      ovf
);
    localparam logic [AW-1:0] RAIL_P = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] RAIL_N = {1'b1, {(AW-1){1'b0}}};

    // R3
    quiet_cross_chk: assert property (@(posedge clk) disable iff (rst)
        !cplx_mode |-> (idle_prods == '0));

    // R6
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !s1_vld |=> ($stable(acc_out) && $stable(ovf)));

    // R5
    clear_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && s1_clr) |=> (ovf == 2'b00));

    for (genvar i = 0; i < 2; i++) begin : g_lane
        // R9
        sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
            (ovf[i] && !(s1_vld && s1_clr)) |=> ovf[i]);

        // R7
        sat_rail_chk: assert property (@(posedge clk) disable iff (rst)
            ($rose(ovf[i]) && $past(s1_sat)) |->
            ((acc_out[i*AW +: AW] == RAIL_P) || (acc_out[i*AW +: AW] == RAIL_N)));
    end

endmodule

bind cmac_dual cmac_dual_chk #(.AW(AW), .PW(PW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .s1_vld     (s1_vld),
    .s1_clr     (s1_clr),
    .s1_sat     (s1_sat),
    .cplx_mode  (cplx_mode),
    .idle_prods (idle_prods),
    .acc_out    (acc_out),
    .ovf        (ovf)
);

// File: tb/cmac_dual_test.sv
`timescale 1ns/1ps
module cmac_dual_test;
    localparam int DW = 16;
    localparam int GUARD = 8;
    localparam int AW = 2*DW + GUARD;
    localparam int OW = AW - DW + 1;
    localparam longint AMAX = (64'sd1 <<< (AW-1)) - 1;
    localparam longint AMIN = -(64'sd1 <<< (AW-1));
    localparam longint OMAX = (64'sd1 <<< (OW-1)) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, acc_clr = 1'b0, cplx_mode = 1'b0, sat_en = 1'b0, rnd_en = 1'b0;
    logic [2*DW-1:0] op_a = '0, op_b = '0;
    logic [2*AW-1:0] acc_out;
    logic [2*OW-1:0] res_out;
    logic [1:0] ovf;

    int checks = 0;
    int errors = 0;
    longint e_acc [2];
    bit     e_ovf [2];

    always #2.5 clk = ~clk;

    cmac_dual #(.DW(DW), .GUARD(GUARD)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .acc_clr(acc_clr),
        .cplx_mode(cplx_mode), .sat_en(sat_en), .rnd_en(rnd_en),
        .op_a(op_a), .op_b(op_b), .acc_out(acc_out), .res_out(res_out), .ovf(ovf)
    );

    function automatic longint wrap_a(longint v);
        return (v <<< (64-AW)) >>> (64-AW);
    endfunction

    function automatic longint scale(longint a, bit r);
        longint y;
        y = (a + (r ? (64'sd1 <<< (DW-2)) : 64'sd0)) >>> (DW-1);
        return (y > OMAX) ? OMAX : y;
    endfunction

    function automatic longint lane_acc(int i);
        return longint'($signed(acc_out[i*AW +: AW]));
    endfunction

    function automatic longint lane_res(int i);
        return longint'($signed(res_out[i*OW +: OW]));
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_lane(int i, longint t, bit clr, bit sat);
        longint s;
        if (clr) begin
            e_acc[i] = t;
            e_ovf[i] = 1'b0;
        end else begin
            s = e_acc[i] + t;
            if (s > AMAX || s < AMIN) begin
                e_ovf[i] = 1'b1;
                e_acc[i] = sat ? ((s > 0) ? AMAX : AMIN) : wrap_a(s);
            end else begin
                e_acc[i] = s;
            end
        end
    endtask

    task automatic issue(input int a0, input int a1, input int b0, input int b1,
                         input bit cm, input bit clr, input bit sat);
        @(negedge clk);
        in_valid  = 1'b1;
        acc_clr   = clr;
        cplx_mode = cm;
        sat_en    = sat;
        op_a = {a1[DW-1:0], a0[DW-1:0]};
        op_b = {b1[DW-1:0], b0[DW-1:0]};
        if (cm) begin
            model_lane(0, longint'(a0)*b0 - longint'(a1)*b1, clr, sat);
            model_lane(1, longint'(a0)*b1 + longint'(a1)*b0, clr, sat);
        end else begin
            model_lane(0, longint'(a0)*b0, clr, sat);
            model_lane(1, longint'(a1)*b1, clr, sat);
        end
        @(posedge clk);
    endtask

    task automatic settle();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic verify(input string req);
        for (int i = 0; i < 2; i++) begin
            chk({req, " acc"}, lane_acc(i), e_acc[i]);
            chk({req, " ovf"}, longint'(ovf[i]), longint'(e_ovf[i]));
            chk({req, " res"}, lane_res(i), scale(e_acc[i], rnd_en));
        end
    endtask

    task automatic t_reset();
        e_acc[0] = 0; e_acc[1] = 0; e_ovf[0] = 0; e_ovf[1] = 0;
        @(negedge clk);
        verify("R11 reset");
    endtask

    task automatic t_complex();
        issue(1200, -700, 300, 45, 1'b1, 1'b1, 1'b0);
        issue(-32768, 32767, -5, 19, 1'b1, 1'b0, 1'b0);
        issue(77, -1, 2048, -2048, 1'b1, 1'b0, 1'b0);
        settle();
        verify("R2 R1 complex");
    endtask

    task automatic t_real();
        issue(-3, 4000, 9, -12000, 1'b0, 1'b1, 1'b0);
        issue(32767, -32768, 32767, -32768, 1'b0, 1'b0, 1'b0);
        issue(-100, 100, -200, 300, 1'b0, 1'b0, 1'b0);
        settle();
        verify("R3 dual real");
    endtask

    task automatic t_switch();
        longint old0;
        issue(10, 20, 30, 40, 1'b1, 1'b1, 1'b0);
        issue(5, -6, 7, 8, 1'b0, 1'b0, 1'b0);
        issue(-9, 11, 13, -15, 1'b1, 1'b0, 1'b0);
        issue(2, 3, 4, 5, 1'b0, 1'b0, 1'b0);
        settle();
        verify("R4 mode switch");
        old0 = e_acc[0];
        issue(100, 0, 100, 0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4 latency early", lane_acc(0), old0);
        @(negedge clk);
        chk("R4 latency late", lane_acc(0), e_acc[0]);
    endtask

    task automatic t_hold();
        @(negedge clk);
        in_valid = 1'b0; acc_clr = 1'b1; cplx_mode = 1'b1; sat_en = 1'b1;
        op_a = 32'h7FFF_8000; op_b = 32'h8000_7FFF;
        repeat (4) @(posedge clk);
        @(negedge clk);
        acc_clr = 1'b0;
        verify("R6 idle hold");
    endtask

    task automatic t_sat_then_clear();
        issue(0, 0, 0, 0, 1'b1, 1'b1, 1'b1);
        for (int n = 0; n < 300; n++)
            issue(-32768, -32768, -32768, 32767, 1'b1, 1'b0, 1'b1);
        settle();
        verify("R7 saturate");
        chk("R7 rail", lane_acc(0), AMAX);
        rnd_en = 1'b1;
        #0.1;
        chk("R10 rail round clamp", lane_res(0), OMAX);
        rnd_en = 1'b0;
        issue(-1, 0, 1, 0, 1'b1, 1'b0, 1'b1);
        settle();
        verify("R9 sticky");
        for (int n = 0; n < 10; n++)
            issue(-32768, -32768, -32768, 32767, 1'b1, 1'b0, 1'b1);
        issue(3, 4, 5, 6, 1'b1, 1'b1, 1'b1);
        settle();
        verify("R5 clear after overflow");
    endtask

    task automatic t_wrap();
        issue(0, 0, 0, 0, 1'b1, 1'b1, 1'b0);
        for (int n = 0; n < 300; n++)
            issue(-32768, -32768, -32768, 32767, 1'b1, 1'b0, 1'b0);
        settle();
        verify("R8 wrap");
        chk("R8 flag", longint'(ovf[0]), 1);
    endtask

    task automatic t_round();
        issue(1, -1, 16384, 16384, 1'b0, 1'b1, 1'b0);
        settle();
        rnd_en = 1'b0;
        #0.1;
        verify("R10 floor");
        chk("R10 floor lane1", lane_res(1), -1);
        rnd_en = 1'b1;
        #0.1;
        verify("R10 round");
        chk("R10 round lane0", lane_res(0), 1);
        chk("R10 acc untouched", lane_acc(0), 16384);
        rnd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_complex();
        t_real();
        t_switch();
        t_hold();
        t_sat_then_clear();
        t_wrap();
        t_round();
        issue(500, 600, 700, 800, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        e_acc[0] = 0; e_acc[1] = 0; e_ovf[0] = 0; e_ovf[1] = 0;
        verify("R11 mid-run reset");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule